// File: doc/BRIEF.md
# Two-Dimensional Frame Line Request Generator

This block turns a programmed frame geometry into a sequence of per-line memory requests. Software loads a line length in bytes, a line pitch (stride), a base address and a line count through a small write-only register port. The write of the line count commits the geometry and launches the frame. The block then issues one request per line, each carrying a byte address and a byte length, over a valid/ready handshake. It raises a single-cycle completion pulse once the last line has been accepted. Splitting requests into bus bursts and moving pixel data are left to downstream logic.

The control is a three-state machine. IDLE accepts register writes. A launch with a legal geometry takes the transition IDLE→LINE. A launch with an illegal geometry stays in IDLE and sets the error flag. LINE presents the current line request. On each accepted request that is not the last, it stays in LINE (transition LINE→LINE on step) and advances the address by the stride. The accepted last request takes the transition LINE→DONE. DONE asserts the completion pulse for one cycle and returns unconditionally via DONE→IDLE.

Top module: `frame_line_reqgen`

## Requirements
- R1: After reset, req_valid, frame_done, busy and cfg_err are all 0.
- R2: Register offsets on cfg_addr are as follows. 0x0 holds the line count in bits 12:0, and writing it launches the frame. 0x4 holds the line length in bytes in bits 15:0. 0xC holds the base address in bits 31:0. 0x8 holds the stride in bits 15:0 and a frame-delay value in bits 31:24. The frame-delay value appears on frame_delay and does not change the stride.
- R3: A launch is a write to 0x0 in IDLE. It is legal when the line length is nonzero, the written line count is nonzero and the stride is at least the line length. After a legal launch, req_valid is 1 on the next cycle with req_addr equal to the base address.
- R4: For line k, from 0 to count-1, req_addr is base + k*stride and req_len is the line length. Exactly count requests are accepted per frame.
- R5: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr holds its value.
- R6: frame_done is 1 for exactly one cycle, in the cycle after the last request is accepted. busy is 1 from the cycle after a legal launch through that pulse.
- R7: An illegal launch (stride smaller than the line length, a zero line length or a zero line count) sets cfg_err on the next cycle, and no request is issued.
- R8: cfg_err clears on the cycle after the next legal launch.
- R9: Register writes, including writes to 0x0, are ignored while busy is 1. A new frame is accepted only after the frame_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted by downstream |
| req_addr | output | 32 | Byte address of the current line |
| req_len | output | 16 | Byte length of the current line |
| frame_done | output | 1 | One-cycle pulse after the last line is accepted |
| busy | output | 1 | Frame in progress (LINE or DONE) |
| cfg_err | output | 1 | Last launch had an illegal geometry |
| frame_delay | output | 8 | Latched frame-delay field |

## Verification
On every cycle, the assertions check the following: a request stays stable under backpressure, the address steps by exactly one stride per accepted non-final line, the completion pulse lasts one cycle, an illegal launch raises the error flag, and registers hold while a frame runs. The first-line address after launch is also checked against the base. Other properties need whole scenarios and are shown by the bench's reference model: the total number of accepted lines, the error flag clearing on a later legal launch, the single-line and stride-equals-length edges, and launch writes issued mid-frame being dropped.

// File: rtl/frl_pkg.sv
package frl_pkg;
    localparam int REG_W   = 32;
    localparam int OFS_W   = 4;
    localparam int DLY_LSB = 24;
    localparam int DLY_W   = 8;

    localparam logic [OFS_W-1:0] OFS_LINES  = 4'h0;
    localparam logic [OFS_W-1:0] OFS_LENGTH = 4'h4;
    localparam logic [OFS_W-1:0] OFS_PITCH  = 4'h8;
    localparam logic [OFS_W-1:0] OFS_BASE   = 4'hC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINE = 2'd1,
        ST_DONE = 2'd2
    } frl_state_e;
endpackage

// File: rtl/frl_regs.sv
module frl_regs
    import frl_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 13,
    parameter int PITCH_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [REG_W-1:0]   wdata,
    input  logic               accept,
    output logic [LEN_W-1:0]   len_q,
    output logic [PITCH_W-1:0] pitch_q,
    output logic [ADDR_W-1:0]  base_q,
    output logic [DLY_W-1:0]   dly_q,
    output logic [CNT_W-1:0]   count_w,
    output logic               launch_ok,
    output logic               err_q
);
    localparam int CMP_W = (PITCH_W > LEN_W) ? PITCH_W : LEN_W;

    logic wr_en;
    logic launch;
    logic geom_ok;
    logic launch_bad;

    assign wr_en      = we && accept;
    assign launch     = wr_en && (ofs == OFS_LINES);
    assign count_w    = wdata[CNT_W-1:0];
    assign geom_ok    = (len_q != '0) && (count_w != '0) &&
                        (CMP_W'(pitch_q) >= CMP_W'(len_q));
    assign launch_ok  = launch && geom_ok;
    assign launch_bad = launch && !geom_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            pitch_q <= '0;
            base_q  <= '0;
            dly_q   <= '0;
        end else if (wr_en) begin
            unique case (ofs)
                OFS_LENGTH: len_q <= wdata[LEN_W-1:0];
                OFS_PITCH: begin
                    pitch_q <= wdata[PITCH_W-1:0];
                    dly_q   <= wdata[DLY_LSB +: DLY_W];
                end
                OFS_BASE:   base_q <= wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          err_q <= 1'b0;
        else if (launch_bad) err_q <= 1'b1;
        else if (launch_ok)  err_q <= 1'b0;
    end

    // R7: an illegal launch raises the flag
    p_bad_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch_bad |=> err_q);

    // R9: geometry holds while a frame is running
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(len_q) && $stable(pitch_q) && $stable(base_q)));
endmodule

// File: rtl/frl_seq.sv
module frl_seq
    import frl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 13,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_ok,
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [CNT_W-1:0]   count,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic               frame_done,
    output logic               idle
);
    frl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic              last;
    logic              take;

    assign last = (rem_q == CNT_W'(1));
    assign take = (state_q == ST_LINE) && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_ok)          state_d = ST_LINE;
            ST_LINE: if (req_ready && last)  state_d = ST_DONE;
            ST_DONE:                         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (state_q == ST_IDLE && launch_ok) begin
            addr_q <= base;
            rem_q  <= count;
        end else if (take && !last) begin
            addr_q <= addr_q + ADDR_W'(pitch);
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    always_comb begin
        req_valid  = (state_q == ST_LINE);
        frame_done = (state_q == ST_DONE);
        idle       = (state_q == ST_IDLE);
        req_addr   = addr_q;
    end

    // R5: request stable under backpressure
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R4: one stride per accepted non-final line
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last) |=> (req_valid && req_addr == $past(req_addr) + ADDR_W'($past(pitch))));

    // R3: first line at the base address
    p_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && launch_ok) |=> (req_valid && req_addr == $past(base)));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !req_valid));
endmodule

// File: rtl/frame_line_reqgen.sv
module frame_line_reqgen
    import frl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 13,
    parameter int PITCH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic              frame_done,
    output logic              busy,
    output logic              cfg_err,
    output logic [DLY_W-1:0]  frame_delay
);
    logic [LEN_W-1:0]   len_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [ADDR_W-1:0]  base_q;
    logic [CNT_W-1:0]   count_w;
    logic               launch_ok;
    logic               idle;

    frl_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .PITCH_W(PITCH_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .ofs(cfg_addr), .wdata(cfg_wdata),
        .accept(idle), .len_q(len_q), .pitch_q(pitch_q), .base_q(base_q),
        .dly_q(frame_delay), .count_w(count_w), .launch_ok(launch_ok), .err_q(cfg_err)
    );

    frl_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PITCH_W(PITCH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch_ok(launch_ok), .base(base_q),
        .pitch(pitch_q), .count(count_w), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .frame_done(frame_done), .idle(idle)
    );

    assign req_len = len_q;
    assign busy    = !idle;

    // R7: no request while the error flag is up
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !req_valid);
endmodule

// File: tb/sim_frame_line_reqgen.sv
`timescale 1ns/1ps
module sim_frame_line_reqgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_ready = 1'b0;
    logic        req_valid, frame_done, busy, cfg_err;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic [7:0]  frame_delay;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int m_st = 0;
    longint m_len = 0, m_pitch = 0, m_base = 0, m_dly = 0, m_cnt = 0, m_line = 0, m_addr = 0;
    int m_err = 0;
    int accepted = 0;

    always #2 clk = ~clk;

    frame_line_reqgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .frame_done(frame_done), .busy(busy), .cfg_err(cfg_err), .frame_delay(frame_delay)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, compared one time unit after every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_len = 0; m_pitch = 0; m_base = 0; m_dly = 0; m_err = 0;
        end else if (m_st == 1) begin
            if (req_ready) begin
                accepted++;
                if (m_line == m_cnt - 1) m_st = 2;
                else begin m_line++; m_addr = (m_addr + m_pitch) & 64'hFFFF_FFFF; end
            end
        end else if (m_st == 2) begin
            m_st = 0;
        end else if (cfg_we) begin
            case (cfg_addr)
                4'h4: m_len = cfg_wdata & 32'hFFFF;
                4'h8: begin m_pitch = cfg_wdata & 32'hFFFF; m_dly = cfg_wdata >> 24; end
                4'hC: m_base = cfg_wdata;
                4'h0: begin
                    if (m_len != 0 && (cfg_wdata & 32'h1FFF) != 0 && m_pitch >= m_len) begin
                        m_cnt = cfg_wdata & 32'h1FFF; m_line = 0; m_addr = m_base;
                        m_st = 1; m_err = 0;
                    end else m_err = 1;
                end
                default: ;
            endcase
        end
        #1;
        if (rst_n) begin
            chk("R4 valid", req_valid, m_st == 1);
            if (m_st == 1) begin
                chk("R4 addr", req_addr, m_addr);
                chk("R4 len", req_len, m_len);
            end
            chk("R6 done", frame_done, m_st == 2);
            chk("R9 busy", busy, m_st != 0);
            chk("R7 err", cfg_err, m_err);
            chk("R2 delay", frame_delay, m_dly);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // mode 0: always ready; mode 1: ready two of three cycles
    task automatic run_frame(input int mode, output int dones);
        dones = 0;
        for (int i = 0; i < 500; i++) begin
            req_ready = (mode == 0) ? 1'b1 : ((i % 3) != 0);
            @(negedge clk);
            if (frame_done) dones++;
            if (!busy) break;
        end
        req_ready = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int d;
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", req_valid, 0);
        chk("R1 done", frame_done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", cfg_err, 0);
        rst_n = 1'b1;

        // R2 delay field beside stride, R3 launch, R4 lines, R6 pulse
        wr(4'h4, 32'd64);
        wr(4'h8, 32'hAB00_0100);
        wr(4'hC, 32'h0000_1000);
        accepted = 0;
        wr(4'h0, 32'd4);
        chk("R3 valid after launch", req_valid, 1);
        chk("R3 first addr", req_addr, 32'h1000);
        chk("R2 frame_delay", frame_delay, 8'hAB);
        req_ready = 1'b1;
        @(negedge clk);
        chk("R2 stride only low bits", req_addr, 32'h1100);
        run_frame(0, d);
        chk("R4 line count", accepted, 4);
        chk("R6 single pulse", d, 1);

        // R5 stall, then irregular ready
        wr(4'h8, 32'h0000_0200);
        accepted = 0;
        wr(4'h0, 32'd5);
        hold = req_addr;
        repeat (3) @(negedge clk);
        chk("R5 valid held", req_valid, 1);
        chk("R5 addr held", req_addr, hold);
        run_frame(1, d);
        chk("R4 line count stalled", accepted, 5);

        // R9 writes during a frame ignored
        accepted = 0;
        wr(4'h0, 32'd3);
        wr(4'h4, 32'd8);
        wr(4'h0, 32'd9);
        chk("R9 len unchanged", req_len, 64);
        run_frame(0, d);
        chk("R9 original count", accepted, 3);

        // R7 illegal geometry
        wr(4'h4, 32'h300);
        wr(4'h0, 32'd2);
        repeat (3) @(negedge clk);
        chk("R7 err stride<len", cfg_err, 1);
        chk("R7 no request", req_valid, 0);
        wr(4'h4, 32'd32);
        wr(4'h0, 32'd0);
        chk("R7 err zero count", cfg_err, 1);
        chk("R7 idle", busy, 0);

        // R8 clear on legal launch; stride equal to length, single line
        wr(4'h8, 32'd32);
        accepted = 0;
        wr(4'h0, 32'd1);
        chk("R8 err cleared", cfg_err, 0);
        run_frame(0, d);
        chk("R4 single line", accepted, 1);
        chk("R6 single-line pulse", d, 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule